// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the write bus cycles of a NOR-style flash bank. Every cycle with the write strobe high is compared with the next step of a multi-cycle unlock sequence. When a complete sequence is recognised, the block issues a one-cycle start strobe for an embedded program, a chip erase or a sector erase. The embedded operation itself is modelled as a busy timer of fixed length that ends with a done pulse. The block also tracks a bypass mode in which program and chip erase need only two cycles. It leaves that mode again on a two-cycle exit sequence.

Sector erase does not begin at once. After a sector-erase command cycle, a window of a parameterised number of clock cycles opens. Each further sector-erase cycle inside the window adds its sector to a bitmap and restarts the window. The erase starts only when the window runs out with no new sector. A digital accelerate flag forces bypass mode. The synchronous reset acts as the bank's hardware reset: it aborts a running operation and returns the bank to read mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `read_mode_o` is 1 and `busy_o`, `done_o`, `bypass_o`, every start strobe and `sect_mask_o` are 0.
- R2: In read mode, the four writes (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), (A,D) pulse `prog_start_o` for one cycle after the last write, with `prog_addr_o`=A and `prog_data_o`=D, and raise `busy_o` on the same cycle. Unlock addresses are compared on address bits 10:0 only.
- R3: The six writes (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x555,0x10) pulse `chip_erase_start_o` for one cycle after the sixth write.
- R4: The same five leading writes followed by (S,0x30) set bit `S[ADDR_W-1 -: SECT_W]` of `sect_mask_o` on the next cycle. `sect_erase_start_o` then pulses exactly TSEA_CYC+1 cycles after that write, provided no other write arrives.
- R5: Each further write with data 0x30 inside the window adds its sector to `sect_mask_o` and restarts the full TSEA_CYC count. Repeating a sector is allowed.
- R6: Any write that does not match the expected next step of a full sequence returns the decoder to read mode and starts nothing. A write with data other than 0x30 inside the sector window also clears `sect_mask_o`.
- R7: The write (0x555,0x20) at the end of the three-cycle unlock prefix sets `bypass_o`. In bypass mode, (any,0xA0) then (A,D) starts a program, and (any,0x80) then (any,0x10) starts a chip erase. When the operation ends, the bank is back in bypass mode.
- R8: In bypass mode, (any,0x90) followed by (any,0x00) clears `bypass_o` and sets `read_mode_o`.
- R9: `accel_i` high sets `bypass_o` on the next cycle. While `accel_i` stays high, the exit sequence leaves the bank in bypass mode.
- R10: `busy_o` stays high for exactly BUSY_CYC cycles. `done_o` pulses for one cycle as `busy_o` falls, and at that point `sect_mask_o` is clear. Every write made while busy is ignored, and the bank returns to its previous mode.
- R11: `rst` high during an operation drops `busy_o` on the next cycle with no `done_o`, and the bank is left in read mode.
- R12: At most one start strobe is high at a time, and `busy_o` rises only together with a start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset; aborts operations |
| wr_en_i | input | 1 | Write cycle valid |
| wr_addr_i | input | ADDR_W | Write address; top SECT_W bits select the sector |
| wr_data_i | input | 8 | Write data / command code |
| accel_i | input | 1 | Accelerate flag; forces bypass mode |
| prog_start_o | output | 1 | One-cycle program start strobe |
| prog_addr_o | output | ADDR_W | Address of the word to program |
| prog_data_o | output | 8 | Data to program |
| chip_erase_start_o | output | 1 | One-cycle chip erase start strobe |
| sect_erase_start_o | output | 1 | One-cycle sector erase start strobe |
| sect_mask_o | output | NUM_SECT | Sectors selected for erase |
| busy_o | output | 1 | Embedded operation running |
| done_o | output | 1 | One-cycle pulse when the operation ends |
| read_mode_o | output | 1 | Bank is in plain read mode |
| bypass_o | output | 1 | Bank is in bypass mode |

## Verification
Properties are evaluated on every cycle for the following: strobe exclusivity, busy rising only with a strobe, the done pulse coinciding with busy falling and a clear mask, read mode excluding both busy and bypass, the accelerate flag forcing bypass, and reset aborting a run. The bench scenarios have to cover the sequence grammar itself: which write orders lead to which strobe, the exact window length and its restart on each added sector, discarding of the sector set on a stray write, and writes ignored while busy. The scoreboard catches any operation that starts when it should not.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_SETUP,
    ST_UNL3,
    ST_UNL4,
    ST_PGM,
    ST_SEWIN,
    ST_RUN,
    ST_BYP,
    ST_BSETUP,
    ST_BEXIT
  } dec_state_t;

  localparam int UNLK_AW = 11;
  localparam logic [UNLK_AW-1:0] UNLK_ADDR_A = 11'h555;
  localparam logic [UNLK_AW-1:0] UNLK_ADDR_B = 11'h2AA;

  localparam logic [7:0] CMD_KEY_A    = 8'hAA;
  localparam logic [7:0] CMD_KEY_B    = 8'h55;
  localparam logic [7:0] CMD_ERASE_SU = 8'h80;
  localparam logic [7:0] CMD_CHIP     = 8'h10;
  localparam logic [7:0] CMD_SECT     = 8'h30;
  localparam logic [7:0] CMD_BYP_IN   = 8'h20;
  localparam logic [7:0] CMD_PROG     = 8'hA0;
  localparam logic [7:0] CMD_BYP_X1   = 8'h90;
  localparam logic [7:0] CMD_BYP_X2   = 8'h00;

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int SECT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic [UNLK_AW-1:0] unlk_addr_i,
  input  logic [SECT_W-1:0]  sect_idx_i,
  input  logic [7:0]         wr_data_i,
  input  logic               accel_i,
  input  logic               win_expire_i,
  input  logic               run_last_i,
  output logic               prog_go_o,
  output logic               ce_go_o,
  output logic               se_go_o,
  output logic               se_add_o,
  output logic [SECT_W-1:0]  se_idx_o,
  output logic               se_cancel_o,
  output dec_state_t         state_o,
  output logic               byp_o
);

  dec_state_t state_q, state_d;
  logic       byp_q, byp_d;
  logic       at_a, at_b, key_a, key_b, force_byp;
  dec_state_t home;

  assign at_a      = (unlk_addr_i == UNLK_ADDR_A);
  assign at_b      = (unlk_addr_i == UNLK_ADDR_B);
  assign key_a     = wr_en_i && at_a && (wr_data_i == CMD_KEY_A);
  assign key_b     = wr_en_i && at_b && (wr_data_i == CMD_KEY_B);
  assign force_byp = accel_i;
  assign home      = (byp_q || accel_i) ? ST_BYP : ST_READ;
  assign se_idx_o  = sect_idx_i;

  always_comb begin
    state_d     = state_q;
    byp_d       = byp_q | accel_i;
    prog_go_o   = 1'b0;
    ce_go_o     = 1'b0;
    se_go_o     = 1'b0;
    se_add_o    = 1'b0;
    se_cancel_o = 1'b0;
    case (state_q)
      ST_READ: begin
        if (force_byp)  state_d = ST_BYP;
        else if (key_a) state_d = ST_UNL1;
      end
      ST_UNL1: begin
        if (force_byp)    state_d = ST_BYP;
        else if (wr_en_i) state_d = key_b ? ST_UNL2 : ST_READ;
      end
      ST_UNL2: begin
        if (force_byp) state_d = ST_BYP;
        else if (wr_en_i) begin
          state_d = ST_READ;
          if (at_a) begin
            case (wr_data_i)
              CMD_ERASE_SU: state_d = ST_SETUP;
              CMD_PROG:     state_d = ST_PGM;
              CMD_BYP_IN: begin
                state_d = ST_BYP;
                byp_d   = 1'b1;
              end
              default:      state_d = ST_READ;
            endcase
          end
        end
      end
      ST_SETUP: begin
        if (force_byp)    state_d = ST_BYP;
        else if (wr_en_i) state_d = key_a ? ST_UNL3 : ST_READ;
      end
      ST_UNL3: begin
        if (force_byp)    state_d = ST_BYP;
        else if (wr_en_i) state_d = key_b ? ST_UNL4 : ST_READ;
      end
      ST_UNL4: begin
        if (force_byp) state_d = ST_BYP;
        else if (wr_en_i) begin
          if (at_a && wr_data_i == CMD_CHIP) begin
            ce_go_o = 1'b1;
            state_d = ST_RUN;
          end else if (wr_data_i == CMD_SECT) begin
            se_add_o = 1'b1;
            state_d  = ST_SEWIN;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_PGM: begin
        if (wr_en_i) begin
          prog_go_o = 1'b1;
          state_d   = ST_RUN;
        end
      end
      ST_SEWIN: begin
        if (win_expire_i) begin
          se_go_o = 1'b1;
          state_d = ST_RUN;
        end else if (wr_en_i) begin
          if (wr_data_i == CMD_SECT) begin
            se_add_o = 1'b1;
          end else begin
            se_cancel_o = 1'b1;
            state_d     = home;
          end
        end
      end
      ST_RUN: begin
        if (run_last_i) state_d = home;
      end
      ST_BYP: begin
        if (wr_en_i) begin
          case (wr_data_i)
            CMD_PROG:     state_d = ST_PGM;
            CMD_ERASE_SU: state_d = ST_BSETUP;
            CMD_BYP_X1:   state_d = ST_BEXIT;
            default:      state_d = ST_BYP;
          endcase
        end
      end
      ST_BSETUP: begin
        if (wr_en_i) begin
          if (wr_data_i == CMD_CHIP) begin
            ce_go_o = 1'b1;
            state_d = ST_RUN;
          end else begin
            state_d = ST_BYP;
          end
        end
      end
      ST_BEXIT: begin
        if (wr_en_i) begin
          if (wr_data_i == CMD_BYP_X2 && !accel_i) begin
            byp_d   = 1'b0;
            state_d = ST_READ;
          end else begin
            state_d = ST_BYP;
          end
        end
      end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_READ;
      byp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      byp_q   <= byp_d;
    end
  end

  assign state_o = state_q;
  assign byp_o   = byp_q;

endmodule

// File: rtl/flash_sect_window.sv
module flash_sect_window #(
  parameter int NUM_SECT = 8,
  parameter int SECT_W   = 3,
  parameter int TSEA_CYC = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                add_i,
  input  logic [SECT_W-1:0]   idx_i,
  input  logic                clear_i,
  output logic                expire_o,
  output logic [NUM_SECT-1:0] mask_o
);

  localparam int CW = $clog2(TSEA_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (add_i) begin
      cnt_q <= CW'(TSEA_CYC);
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = act_q && (cnt_q == '0);

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    logic sel_q;
    always_ff @(posedge clk) begin
      if (rst || clear_i)                       sel_q <= 1'b0;
      else if (add_i && idx_i == SECT_W'(s))    sel_q <= 1'b1;
    end
    assign mask_o[s] = sel_q;
  end

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int BUSY_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic last_o
);

  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(BUSY_CYC - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign last_o = busy_q && (cnt_q == '0);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_SECT = 8,
  parameter int TSEA_CYC = 64,
  parameter int BUSY_CYC = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [7:0]          wr_data_i,
  input  logic                accel_i,
  output logic                prog_start_o,
  output logic [ADDR_W-1:0]   prog_addr_o,
  output logic [7:0]          prog_data_o,
  output logic                chip_erase_start_o,
  output logic                sect_erase_start_o,
  output logic [NUM_SECT-1:0] sect_mask_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                read_mode_o,
  output logic                bypass_o
);

  localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;

  logic              prog_go, ce_go, se_go, se_add, se_cancel;
  logic [SECT_W-1:0] se_idx;
  logic              win_expire, run_last;
  dec_state_t        state;
  logic              byp;

  flash_seq_fsm #(
    .SECT_W (SECT_W)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .wr_en_i      (wr_en_i),
    .unlk_addr_i  (wr_addr_i[UNLK_AW-1:0]),
    .sect_idx_i   (wr_addr_i[ADDR_W-1 -: SECT_W]),
    .wr_data_i    (wr_data_i),
    .accel_i      (accel_i),
    .win_expire_i (win_expire),
    .run_last_i   (run_last),
    .prog_go_o    (prog_go),
    .ce_go_o      (ce_go),
    .se_go_o      (se_go),
    .se_add_o     (se_add),
    .se_idx_o     (se_idx),
    .se_cancel_o  (se_cancel),
    .state_o      (state),
    .byp_o        (byp)
  );

  flash_sect_window #(
    .NUM_SECT (NUM_SECT),
    .SECT_W   (SECT_W),
    .TSEA_CYC (TSEA_CYC)
  ) u_win (
    .clk      (clk),
    .rst      (rst),
    .add_i    (se_add),
    .idx_i    (se_idx),
    .clear_i  (se_cancel | run_last),
    .expire_o (win_expire),
    .mask_o   (sect_mask_o)
  );

  flash_busy_timer #(
    .BUSY_CYC (BUSY_CYC)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start_i (prog_go | ce_go | se_go),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .last_o  (run_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_start_o       <= 1'b0;
      chip_erase_start_o <= 1'b0;
      sect_erase_start_o <= 1'b0;
      prog_addr_o        <= '0;
      prog_data_o        <= '0;
    end else begin
      prog_start_o       <= prog_go;
      chip_erase_start_o <= ce_go;
      sect_erase_start_o <= se_go;
      if (prog_go) begin
        prog_addr_o <= wr_addr_i;
        prog_data_o <= wr_data_i;
      end
    end
  end

  assign read_mode_o = (state == ST_READ);
  assign bypass_o    = byp;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int NUM_SECT = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                accel_i,
  input logic                prog_start_o,
  input logic                chip_erase_start_o,
  input logic                sect_erase_start_o,
  input logic [NUM_SECT-1:0] sect_mask_o,
  input logic                busy_o,
  input logic                done_o,
  input logic                read_mode_o,
  input logic                bypass_o
);

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_start_o, chip_erase_start_o, sect_erase_start_o}));

  assert_busy_cause_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (prog_start_o || chip_erase_start_o || sect_erase_start_o));

  assert_prog_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    prog_start_o |=> !prog_start_o);

  assert_se_mask_R4: assert property (@(posedge clk) disable iff (rst)
    sect_erase_start_o |-> (sect_mask_o != '0));

  assert_done_edge_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(busy_o) && !busy_o));

  assert_done_mask_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (sect_mask_o == '0));

  assert_read_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !(read_mode_o && busy_o));

  assert_mode_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(read_mode_o && bypass_o));

  assert_accel_byp_R9: assert property (@(posedge clk) disable iff (rst)
    accel_i |=> bypass_o);

  assert_abort_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy_o && !done_o && read_mode_o));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.NUM_SECT(NUM_SECT)) i_chk (
  .clk                (clk),
  .rst                (rst),
  .accel_i            (accel_i),
  .prog_start_o       (prog_start_o),
  .chip_erase_start_o (chip_erase_start_o),
  .sect_erase_start_o (sect_erase_start_o),
  .sect_mask_o        (sect_mask_o),
  .busy_o             (busy_o),
  .done_o             (done_o),
  .read_mode_o        (read_mode_o),
  .bypass_o           (bypass_o)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

  localparam int AW = 16;
  localparam int NS = 8;
  localparam int TS = 8;
  localparam int BC = 12;
  localparam int K_PRG = 0, K_CE = 1, K_SE = 2, K_DONE = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          accel = 1'b0;
  logic          prog_start, ce_start, se_start, busy, done, read_mode, bypass;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data;
  logic [NS-1:0] mask;

  flash_cmd_decoder #(
    .ADDR_W(AW), .NUM_SECT(NS), .TSEA_CYC(TS), .BUSY_CYC(BC)
  ) i_flash_cmd_decoder (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .accel_i(accel),
    .prog_start_o(prog_start), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
    .chip_erase_start_o(ce_start), .sect_erase_start_o(se_start),
    .sect_mask_o(mask), .busy_o(busy), .done_o(done),
    .read_mode_o(read_mode), .bypass_o(bypass)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int          kind;
    logic [31:0] val;
    string       req;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int k, input logic [31:0] v, input string req);
    sb.push_back('{kind: k, val: v, req: req});
  endtask

  task automatic observe(input int k, input logic [31:0] v);
    exp_t e;
    n_chk++;
    if (sb.size() == 0) begin
      n_fail++;
      $display("FAIL R6 unexpected event kind=%0d val=%h expected none", k, v);
    end else begin
      e = sb.pop_front();
      if (e.kind != k || e.val != v) begin
        n_fail++;
        $display("FAIL %s event actual kind=%0d val=%h expected kind=%0d val=%h",
                 e.req, k, v, e.kind, e.val);
      end
    end
  endtask

  // monitor: compares produced events with the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (prog_start) observe(K_PRG, {8'h00, prog_addr, prog_data});
        if (ce_start)   observe(K_CE, 32'h0);
        if (se_start)   observe(K_SE, 32'(mask));
        if (done)       observe(K_DONE, 32'h0);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic unlock();
    wr(16'h0555, 8'hAA);
    wr(16'h02AA, 8'h55);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    int n;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(read_mode == 1'b1 && busy == 1'b0 && bypass == 1'b0 && mask == '0 &&
          !prog_start && !ce_start && !se_start && !done,
          "R1", "reset state", {read_mode, busy, bypass}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    check(read_mode == 1'b1 && busy == 1'b0, "R1", "after reset", {read_mode, busy}, 2'b10);

    // R2: full program sequence
    expect_ev(K_PRG, {8'h00, 16'h1234, 8'h5A}, "R2");
    expect_ev(K_DONE, 32'h0, "R10");
    unlock();
    wr(16'h0555, 8'hA0);
    wr(16'h1234, 8'h5A);
    check(busy == 1'b1, "R2", "busy with strobe", busy, 1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == BC, "R10", "busy length", n, BC);
    check(read_mode == 1'b1, "R10", "back to read", read_mode, 1);

    // R3: chip erase, R10: writes during busy ignored
    expect_ev(K_CE, 32'h0, "R3");
    expect_ev(K_DONE, 32'h0, "R10");
    unlock();
    wr(16'h0555, 8'h80);
    unlock();
    wr(16'h0555, 8'h10);
    check(busy == 1'b1, "R3", "chip erase busy", busy, 1);
    unlock();
    wr(16'h0555, 8'hA0);
    wr(16'h4000, 8'h11);
    wait_idle();
    repeat (3) @(negedge clk);
    check(read_mode == 1'b1 && busy == 1'b0, "R10", "ignored writes", {read_mode, busy}, 2'b10);

    // R4: single sector erase with exact window length
    expect_ev(K_SE, 32'h04, "R4");
    expect_ev(K_DONE, 32'h0, "R10");
    unlock();
    wr(16'h0555, 8'h80);
    unlock();
    wr(16'h4000, 8'h30);
    check(mask == 8'h04, "R4", "mask after add", mask, 8'h04);
    n = 0;
    while (!se_start) begin @(negedge clk); n++; end
    check(n == TS + 1, "R4", "window length", n, TS + 1);
    wait_idle();
    check(mask == '0, "R10", "mask cleared at end", mask, 0);

    // R5: further sectors extend the window
    expect_ev(K_SE, 32'h82, "R5");
    expect_ev(K_DONE, 32'h0, "R10");
    unlock();
    wr(16'h0555, 8'h80);
    unlock();
    wr(16'h2000, 8'h30);
    repeat (TS - 2) @(negedge clk);
    wr(16'hE000, 8'h30);
    repeat (TS - 2) @(negedge clk);
    wr(16'h2000, 8'h30);
    check(mask == 8'h82, "R5", "mask two sectors", mask, 8'h82);
    n = 0;
    while (!se_start) begin @(negedge clk); n++; end
    check(n == TS + 1, "R5", "window restarted", n, TS + 1);
    wait_idle();

    // R6: mismatches return to read mode
    unlock();
    wr(16'h0555, 8'h77);
    check(read_mode == 1'b1, "R6", "bad command", read_mode, 1);
    wr(16'h0555, 8'hAA);
    wr(16'h02AA, 8'h56);
    check(read_mode == 1'b1, "R6", "bad second key", read_mode, 1);
    wr(16'h0555, 8'hA0);
    wr(16'h1000, 8'h33);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R6", "no program after mismatch", busy, 0);
    unlock();
    wr(16'h0555, 8'h80);
    unlock();
    wr(16'h6000, 8'h30);
    wr(16'h0000, 8'hF0);
    check(mask == '0 && read_mode == 1'b1, "R6", "window discarded", {mask, read_mode}, 9'h001);
    repeat (TS + 4) @(negedge clk);
    check(busy == 1'b0, "R6", "no erase after discard", busy, 0);

    // R7: bypass entry and shortened sequences
    unlock();
    wr(16'h0555, 8'h20);
    check(bypass == 1'b1 && read_mode == 1'b0, "R7", "bypass entered", {bypass, read_mode}, 2'b10);
    expect_ev(K_PRG, {8'h00, 16'h0F00, 8'hC3}, "R7");
    expect_ev(K_DONE, 32'h0, "R10");
    wr(16'h0000, 8'hA0);
    wr(16'h0F00, 8'hC3);
    wait_idle();
    check(bypass == 1'b1, "R7", "bypass after program", bypass, 1);
    expect_ev(K_CE, 32'h0, "R7");
    expect_ev(K_DONE, 32'h0, "R10");
    wr(16'h0000, 8'h80);
    wr(16'h0000, 8'h10);
    wait_idle();
    check(bypass == 1'b1 && read_mode == 1'b0, "R7", "bypass after erase", {bypass, read_mode}, 2'b10);

    // R8: exit bypass
    wr(16'h0000, 8'h90);
    wr(16'h0000, 8'h00);
    check(bypass == 1'b0 && read_mode == 1'b1, "R8", "bypass left", {bypass, read_mode}, 2'b01);

    // R9: accelerate forces bypass
    accel = 1'b1;
    @(negedge clk);
    check(bypass == 1'b1, "R9", "accel enters bypass", bypass, 1);
    wr(16'h0000, 8'h90);
    wr(16'h0000, 8'h00);
    check(bypass == 1'b1, "R9", "exit blocked by accel", bypass, 1);
    expect_ev(K_PRG, {8'h00, 16'h0ABC, 8'h3C}, "R9");
    expect_ev(K_DONE, 32'h0, "R10");
    wr(16'h0000, 8'hA0);
    wr(16'h0ABC, 8'h3C);
    wait_idle();
    accel = 1'b0;
    wr(16'h0000, 8'h90);
    wr(16'h0000, 8'h00);
    check(read_mode == 1'b1 && bypass == 1'b0, "R8", "exit after accel", {read_mode, bypass}, 2'b10);

    // R11: hardware reset aborts chip erase
    expect_ev(K_CE, 32'h0, "R11");
    unlock();
    wr(16'h0555, 8'h80);
    unlock();
    wr(16'h0555, 8'h10);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy == 1'b0 && read_mode == 1'b1 && bypass == 1'b0, "R11", "abort",
          {busy, read_mode, bypass}, 3'b010);
    repeat (BC + 4) @(negedge clk);
    check(busy == 1'b0, "R11", "stays idle", busy, 0);

    check(sb.size() == 0, "R12", "pending events", sb.size(), 0);
    summary();
  end

endmodule